// File: doc/BRIEF.md
# Per-Pin Interrupt and Wake Event Detector

This block sits after a pin's glitch filter and turns the filtered level into two sticky status bits per pin. One is interrupt status and the other is wake status. Each pin has its own trigger configuration:

- **Trigger mode:** level or edge.
- **Polarity code:** two bits.
- **Interrupt enable:** controls whether interrupt status is captured.
- **Delivery mask:** a 1 allows delivery.
- **Wake enables:** three bits, one for each low-power state.

A pin reports pending to a downstream summary aggregator when any of its status is set and delivery is allowed. Software clears each status with a one-cycle write-one-to-clear strobe.

In edge mode a detected edge latches status, and the status holds until it is cleared. In level mode status is set on every cycle that the active level is present. Clearing therefore only takes effect once the level has gone away. Wake status is raised by the same detected event, but only when the wake enable that matches the current power state is set.

Top module: `pin_event_detector`

## Requirements
- R1: While reset is asserted, and on the first edge after it, irqStatus, wakeStatus and pending are all 0.
- R2: In edge mode (levelMode=0) with polarity code 2'b00, a 0-to-1 change of pinLevel sets irqStatus on the next clock edge. The status then holds until cleared, even while the pin stays high.
- R3: In edge mode with polarity code 2'b01, only a 1-to-0 change of pinLevel sets irqStatus.
- R4: Polarity code 2'b10 detects both edges in edge mode. In level mode, codes 2'b10 and 2'b11 never raise status. In edge mode, code 2'b11 never raises status.
- R5: In level mode, polarity code 2'b00 sets irqStatus on every clock while pinLevel is 1, and code 2'b01 does so while pinLevel is 0. A clear while the level persists does not leave the status at 0.
- R6: With irqEnable=0 a pin's events do not set its irqStatus.
- R7: pending[i] equals (irqStatus[i] OR wakeStatus[i]) AND irqUnmask[i]. The unmask bit does not stop status capture.
- R8: A detected event sets wakeStatus only when the wake enable selected by powerState is 1. For pin i, powerState 1 selects wakeEn[3i], 2 selects wakeEn[3i+1], and 3 selects wakeEn[3i+2]. powerState 0 (running) never sets wake status. Wake status does not depend on irqEnable.
- R9: A 1 on clearIrq[i] or clearWake[i] clears only that pin's status. A new event in the same cycle as the clear leaves the status set.
- R10: The first clock edge after reset release infers no edge from the pin's earlier level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinLevel | input | NUM_PINS | Filtered pin levels |
| powerState | input | 2 | 0 running, 1 idle, 2 suspend, 3 off |
| levelMode | input | NUM_PINS | 1 level trigger, 0 edge trigger |
| activeSel | input | 2*NUM_PINS | Polarity code per pin, bits [2i+1:2i] |
| irqEnable | input | NUM_PINS | Interrupt status capture enable |
| irqUnmask | input | NUM_PINS | 1 allows the pin to report pending |
| wakeEn | input | 3*NUM_PINS | Wake enables per pin, bits [3i+2:3i] |
| clearIrq | input | NUM_PINS | Write-one-to-clear strobe for interrupt status |
| clearWake | input | NUM_PINS | Write-one-to-clear strobe for wake status |
| irqStatus | output | NUM_PINS | Sticky interrupt status |
| wakeStatus | output | NUM_PINS | Sticky wake status |
| pending | output | NUM_PINS | Status present and delivery allowed |

## Verification
The bench targets a clear that collides with a fresh event, in both edge and level mode. A design where clear takes priority would drop that event and report nothing.

It holds a pin high across reset release, which catches a design that invents a rising edge from a stale history register. It also drives the both-edges code in level mode, where a careless decoder would fire on every cycle.

Finally, it walks the power-state encoding with a single wake enable set per pin. An off-by-one in wake-bit selection would then wake the wrong pin or wake while running.

// File: rtl/evdet_pkg.sv
package evdet_pkg;

  // Polarity codes; the decoder depends on these values.
  typedef enum logic [1:0] {
    POL_HIGH = 2'b00,
    POL_LOW  = 2'b01,
    POL_BOTH = 2'b10,
    POL_NONE = 2'b11
  } polSel_e;

  typedef enum logic [1:0] {
    PWR_RUN     = 2'd0,
    PWR_IDLE    = 2'd1,
    PWR_SUSPEND = 2'd2,
    PWR_OFF     = 2'd3
  } pwrState_e;

  localparam int WAKE_STATES = 3;

  // Per-pin strobes from control to the status datapath.
  typedef struct packed {
    logic setIrq;
    logic setWake;
    logic clrIrq;
    logic clrWake;
  } pinStrobe_t;

endpackage

// File: rtl/evdet_ctrl.sv
module evdet_ctrl
  import evdet_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PINS-1:0]               pinLevel,
  input  logic [1:0]                        powerState,
  input  logic [NUM_PINS-1:0]               levelMode,
  input  logic [2*NUM_PINS-1:0]             activeSel,
  input  logic [NUM_PINS-1:0]               irqEnable,
  input  logic [WAKE_STATES*NUM_PINS-1:0]   wakeEn,
  input  logic [NUM_PINS-1:0]               clearIrq,
  input  logic [NUM_PINS-1:0]               clearWake,
  output pinStrobe_t [NUM_PINS-1:0]         strobes
);

  logic [NUM_PINS-1:0] prevLevel;
  logic                primed;

  // Edge history; primed keeps the first cycle after reset from seeing an edge (R10).
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLevel <= '0;
      primed    <= 1'b0;
    end else begin
      prevLevel <= pinLevel;
      primed    <= 1'b1;
    end
  end

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    polSel_e    pol;
    logic       rising;
    logic       falling;
    logic       hit;
    logic       wakeGate;
    pinStrobe_t stb;

    assign pol     = polSel_e'(activeSel[2*g +: 2]);
    assign rising  = primed &  pinLevel[g] & ~prevLevel[g];
    assign falling = primed & ~pinLevel[g] &  prevLevel[g];

    always_comb begin
      hit = 1'b0;
      if (levelMode[g]) begin
        case (pol)
          POL_HIGH: hit = pinLevel[g];
          POL_LOW:  hit = ~pinLevel[g];
          default:  hit = 1'b0;
        endcase
      end else begin
        case (pol)
          POL_HIGH: hit = rising;
          POL_LOW:  hit = falling;
          POL_BOTH: hit = rising | falling;
          default:  hit = 1'b0;
        endcase
      end
    end

    always_comb begin
      case (pwrState_e'(powerState))
        PWR_IDLE:    wakeGate = wakeEn[WAKE_STATES*g];
        PWR_SUSPEND: wakeGate = wakeEn[WAKE_STATES*g + 1];
        PWR_OFF:     wakeGate = wakeEn[WAKE_STATES*g + 2];
        default:     wakeGate = 1'b0;
      endcase
    end

    always_comb begin
      stb.setIrq  = hit & irqEnable[g];
      stb.setWake = hit & wakeGate;
      stb.clrIrq  = clearIrq[g];
      stb.clrWake = clearWake[g];
    end

    assign strobes[g] = stb;

    // A single-polarity edge cannot fire in two consecutive cycles.
    AST_EDGE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
      (hit && !levelMode[g] && pol == POL_HIGH) |=>
      !(hit && !levelMode[g] && pol == POL_HIGH)); // R2
  end

endmodule

// File: rtl/evdet_status.sv
module evdet_status
  import evdet_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  pinStrobe_t [NUM_PINS-1:0] strobes,
  output logic [NUM_PINS-1:0]       irqStatus,
  output logic [NUM_PINS-1:0]       wakeStatus
);

  for (genvar g = 0; g < NUM_PINS; g++) begin : gPin
    logic irqQ;
    logic wakeQ;

    // Set has priority over a simultaneous clear.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        irqQ  <= 1'b0;
        wakeQ <= 1'b0;
      end else begin
        irqQ  <= strobes[g].setIrq  | (irqQ  & ~strobes[g].clrIrq);
        wakeQ <= strobes[g].setWake | (wakeQ & ~strobes[g].clrWake);
      end
    end

    assign irqStatus[g]  = irqQ;
    assign wakeStatus[g] = wakeQ;

    AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rstN)
      (irqQ && !strobes[g].clrIrq) |=> irqQ); // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
      strobes[g].setIrq |=> irqQ); // R9
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (strobes[g].clrWake && !strobes[g].setWake) |=> !wakeQ); // R9
  end

endmodule

// File: rtl/pin_event_detector.sv
module pin_event_detector
  import evdet_pkg::*;
#(
  parameter int NUM_PINS = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [NUM_PINS-1:0]     pinLevel,
  input  logic [1:0]              powerState,
  input  logic [NUM_PINS-1:0]     levelMode,
  input  logic [2*NUM_PINS-1:0]   activeSel,
  input  logic [NUM_PINS-1:0]     irqEnable,
  input  logic [NUM_PINS-1:0]     irqUnmask,
  input  logic [3*NUM_PINS-1:0]   wakeEn,
  input  logic [NUM_PINS-1:0]     clearIrq,
  input  logic [NUM_PINS-1:0]     clearWake,
  output logic [NUM_PINS-1:0]     irqStatus,
  output logic [NUM_PINS-1:0]     wakeStatus,
  output logic [NUM_PINS-1:0]     pending
);

  pinStrobe_t [NUM_PINS-1:0] strobes;

  evdet_ctrl #(.NUM_PINS(NUM_PINS)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .pinLevel   (pinLevel),
    .powerState (powerState),
    .levelMode  (levelMode),
    .activeSel  (activeSel),
    .irqEnable  (irqEnable),
    .wakeEn     (wakeEn),
    .clearIrq   (clearIrq),
    .clearWake  (clearWake),
    .strobes    (strobes)
  );

  evdet_status #(.NUM_PINS(NUM_PINS)) u_status (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .irqStatus  (irqStatus),
    .wakeStatus (wakeStatus)
  );

  assign pending = (irqStatus | wakeStatus) & irqUnmask;

  for (genvar g = 0; g < NUM_PINS; g++) begin : gChk
    AST_WAKE_NOT_RUNNING: assert property (@(posedge clk) disable iff (!rstN)
      $rose(wakeStatus[g]) |-> ($past(powerState) != PWR_RUN)); // R8
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqStatus[g]) |-> $past(irqEnable[g])); // R6
    AST_LEVEL_NO_BOTH: assert property (@(posedge clk) disable iff (!rstN)
      $rose(irqStatus[g]) |-> !($past(levelMode[g]) && $past(activeSel[2*g+1]))); // R4
  end

endmodule

// File: tb/pin_event_detector_bench.sv
module pin_event_detector_bench;

  localparam int N = 4;

  logic           clk = 1'b0;
  logic           rstN;
  logic [N-1:0]   pinLevel, levelMode, irqEnable, irqUnmask, clearIrq, clearWake;
  logic [1:0]     powerState;
  logic [2*N-1:0] activeSel;
  logic [3*N-1:0] wakeEn;
  logic [N-1:0]   irqStatus, wakeStatus, pending;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk; // 50 MHz

  pin_event_detector #(.NUM_PINS(N)) u_pin_event_detector (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .powerState(powerState),
    .levelMode(levelMode), .activeSel(activeSel), .irqEnable(irqEnable),
    .irqUnmask(irqUnmask), .wakeEn(wakeEn), .clearIrq(clearIrq),
    .clearWake(clearWake), .irqStatus(irqStatus), .wakeStatus(wakeStatus),
    .pending(pending)
  );

  // Behavioural reference model
  bit mPrev [N];
  bit mIrq  [N];
  bit mWake [N];
  bit mPrimed;

  always @(posedge clk) begin
    if (!rstN) begin
      mPrimed = 0;
      for (int i = 0; i < N; i++) begin mPrev[i] = 0; mIrq[i] = 0; mWake[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        bit p, ev, up, dn, wk;
        int sel;
        p   = pinLevel[i];
        sel = int'(activeSel[2*i +: 2]);
        up  = mPrimed && p && !mPrev[i];
        dn  = mPrimed && !p && mPrev[i];
        if (levelMode[i]) ev = (sel == 0) ? p : (sel == 1) ? !p : 1'b0;
        else ev = (sel == 0) ? up : (sel == 1) ? dn : (sel == 2) ? (up || dn) : 1'b0;
        wk = (powerState == 0) ? 1'b0 : wakeEn[3*i + int'(powerState) - 1];
        mIrq[i]  = (ev && irqEnable[i]) || (mIrq[i] && !clearIrq[i]);
        mWake[i] = (ev && wk) || (mWake[i] && !clearWake[i]);
        mPrev[i] = p;
      end
      mPrimed = 1;
    end
  end

  // Compare against the model every clock, 5 ns after the edge.
  always @(posedge clk) begin
    #5;
    if (!done) begin
      for (int i = 0; i < N; i++) begin
        bit ePend;
        ePend = (mIrq[i] || mWake[i]) && irqUnmask[i];
        checks++;
        if (irqStatus[i] !== mIrq[i] || wakeStatus[i] !== mWake[i] || pending[i] !== ePend) begin
          fails++;
          $display("FAIL R2/R5/R8 model pin %0d: actual irq=%b wake=%b pend=%b expected irq=%b wake=%b pend=%b",
                   i, irqStatus[i], wakeStatus[i], pending[i], mIrq[i], mWake[i], ePend);
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doReset();
    rstN = 1'b0;
    step(2);
    check("R1 irq in reset", 32'(irqStatus), 0);
    check("R1 wake in reset", 32'(wakeStatus), 0);
    check("R1 pending in reset", 32'(pending), 0);
    rstN = 1'b1;
    step(2);
  endtask

  initial begin
    rstN = 0; pinLevel = 0; levelMode = 0; irqEnable = '1; irqUnmask = '1;
    clearIrq = 0; clearWake = 0; powerState = 0; activeSel = 0; wakeEn = 0;

    // R10 / R2: pin0 high through reset
    pinLevel = 4'b0001;
    doReset();
    check("R10 no edge after reset", 32'(irqStatus), 0);
    pinLevel = 4'b0011; step(1);
    check("R2 rising sets", 32'(irqStatus), 32'b0010);
    step(3);
    check("R2 holds", 32'(irqStatus), 32'b0010);
    clearIrq = 4'b0010; step(1); clearIrq = 0;
    check("R9 clear", 32'(irqStatus), 0);
    step(2);
    check("R2 no reassert in edge mode", 32'(irqStatus), 0);
    pinLevel = 4'b0001; step(1);
    pinLevel = 4'b0011; clearIrq = 4'b0010; step(1); clearIrq = 0;
    check("R9 event beats clear", 32'(irqStatus), 32'b0010);

    // R3: falling
    activeSel = 8'b00_01_00_00; pinLevel = 0;
    doReset();
    pinLevel = 4'b0100; step(1);
    check("R3 rise ignored", 32'(irqStatus), 0);
    pinLevel = 4'b0000; step(1);
    check("R3 falling sets", 32'(irqStatus), 32'b0100);

    // R4: both edges and illegal combinations
    activeSel = 8'b10_00_00_00; pinLevel = 0;
    doReset();
    pinLevel = 4'b1000; step(1);
    check("R4 both rise", 32'(irqStatus), 32'b1000);
    clearIrq = 4'b1000; step(1); clearIrq = 0;
    pinLevel = 4'b0000; step(1);
    check("R4 both fall", 32'(irqStatus), 32'b1000);
    clearIrq = 4'b1000; levelMode = 4'b1000; pinLevel = 4'b1000; step(1); clearIrq = 0;
    step(2);
    check("R4 both in level mode silent", 32'(irqStatus), 0);
    activeSel = 8'b11_00_00_00; pinLevel = 0; step(2);
    check("R4 code 11 silent", 32'(irqStatus), 0);

    // R5: level mode
    levelMode = 4'b0001; activeSel = 0; pinLevel = 0;
    doReset();
    check("R5 inactive level", 32'(irqStatus), 0);
    pinLevel = 4'b0001; step(1);
    check("R5 high level sets", 32'(irqStatus), 32'b0001);
    clearIrq = 4'b0001; step(1); clearIrq = 0;
    check("R5 reasserts after clear", 32'(irqStatus), 32'b0001);
    pinLevel = 0; clearIrq = 4'b0001; step(1); clearIrq = 0;
    check("R5 clear once level gone", 32'(irqStatus), 0);
    activeSel = 8'b00_00_00_01; step(1);
    check("R5 low level sets", 32'(irqStatus), 32'b0001);

    // R6, R9, R7
    levelMode = 0; activeSel = 0; irqEnable = 4'b1101; pinLevel = 0;
    doReset();
    pinLevel = 4'b0011; step(1);
    check("R6 disabled pin ignored", 32'(irqStatus), 32'b0001);
    clearIrq = 4'b0010; step(1); clearIrq = 0;
    check("R9 other pin untouched", 32'(irqStatus), 32'b0001);
    irqUnmask = 4'b1110; step(1);
    check("R7 masked not pending", 32'(pending), 0);
    check("R7 status kept when masked", 32'(irqStatus), 32'b0001);
    irqUnmask = 4'b1111; step(1);
    check("R7 unmasked pending", 32'(pending), 32'b0001);
    irqUnmask = 0; pinLevel = 4'b0111; step(1);
    check("R7 capture while masked", 32'(irqStatus), 32'b0101);
    check("R7 pending off while masked", 32'(pending), 0);

    // R8: wake
    irqEnable = 0; irqUnmask = '1; powerState = 2'd0; wakeEn = '1; pinLevel = 0;
    doReset();
    pinLevel = 4'b0001; step(1);
    check("R8 no wake while running", 32'(wakeStatus), 0);
    powerState = 2'd2; wakeEn = 12'b000_001_010_000; pinLevel = 4'b0111; step(1);
    check("R8 suspend wake", 32'(wakeStatus), 32'b0010);
    check("R7 pending from wake", 32'(pending), 32'b0010);
    powerState = 2'd1; pinLevel = 4'b0001; step(1);
    pinLevel = 4'b0111; step(1);
    check("R8 idle wake", 32'(wakeStatus), 32'b0110);
    clearWake = 4'b0010; step(1); clearWake = 0;
    check("R9 wake clear", 32'(wakeStatus), 32'b0100);

    step(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule